// File: doc/BRIEF.md
# Scratchpad Write and Readback Engine

This block is the byte-level command engine for a 32-byte staging buffer that sits in front of a paged byte memory. A bus front end hands it complete bytes, each with a count of the bits actually received, plus requests for outgoing bytes and a transaction-end pulse. Two commands are served. The write command (0Fh) captures a two-byte target address and then fills the buffer from the start offset onward. The read command (AAh) plays back the address, a status byte, the buffered bytes and an inverted CRC16.

What lands in the buffer is not always what the host sent. On a page flagged as locked, each byte is taken from the memory, so the sent byte has no effect. On a page flagged as one-time-programmable, each stored byte is the bitwise AND of the sent byte and the memory byte. A trailing byte with fewer than eight bits is dropped and raises a partial-byte flag. The write keeps its own running CRC16, which the host may fetch once the last buffer offset has been written. Per-page protection comes from plain input vectors. The memory is a synchronous model with a load port.

Top module: `sp_engine`

## Requirements
- R1: After reset, the address registers, ending offset, partial flag and all buffer bytes are zero, tx_valid is 0, and a byte request with no command in progress returns FFh.
- R2: After 0Fh, the first and second full bytes are taken as the low (TA1) and high (TA2) address bytes. Data bytes are stored at increasing offsets starting at TA1[4:0]. The ending offset starts equal to TA1[4:0] and then follows the offset of the last full byte stored.
- R3: During write data, a byte with rx_bits below 8 is discarded and sets the partial flag. Every later byte is ignored until txn_end.
- R4: If the page bit of page_wp is set, each buffer byte is loaded from memory at {page, offset} and the sent byte is ignored. The page index is address bits 8:5, which are TA2[0] followed by TA1[7:5].
- R5: If the page bit of page_eprom is set and page_wp is clear, each buffer byte is the AND of the sent byte and the memory byte. page_wp wins when both bits are set.
- R6: Full bytes that arrive after offset 31 has been written are ignored. After offset 31 has been written, byte requests return the inverted write CRC, low byte first, then FFh. Before that, byte requests return FFh. The write CRC covers 0Fh, TA1, TA2 and every stored-position data byte as sent.
- R7: After AAh, byte requests return TA1, TA2, then the status byte, then buffer bytes from offset TA1[4:0] through the ending offset. The status byte is bit 7 = 0, bit 6 = 0, bit 5 = partial flag, bits 4:0 = ending offset. Reading never changes the buffer.
- R8: After the read data come the inverted CRC16 (low byte, then high byte) and then FFh for every further request. This CRC starts at 0 and covers AAh followed by every byte transmitted before it. The CRC uses polynomial x^16+x^15+x^2+1, processed LSB first.
- R9: A new 0Fh clears the partial flag. txn_end returns the engine to idle from any state. An unknown command byte changes nothing, and requests return FFh until txn_end.
- R10: tx_valid is high exactly in the cycle after a cycle with tx_req high, and tx_byte is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_end | input | 1 | Bus reset seen: end the current command |
| rx_valid | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte, LSB first on the wire |
| rx_bits | input | 4 | Number of bits received for this byte (8 = full) |
| tx_req | input | 1 | Host wants the next outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_byte | output | 8 | Outgoing byte |
| page_wp | input | PAGES | Per-page locked flag |
| page_eprom | input | PAGES | Per-page AND-merge flag |
| mem_we | input | 1 | Memory model load strobe |
| mem_waddr | input | ADDR_W | Memory model load address |
| mem_wdata | input | 8 | Memory model load data |

## Verification
Writes are driven at several start offsets and lengths on open, locked, AND-merge and doubly flagged pages, each page preloaded with a distinct pattern. This separates a stored sent byte, a stored memory byte and their AND in the read-back. One write starts near the end of the buffer and overruns it, and one fills all 32 bytes. Both expose the ignore-after-top rule and the write CRC read, while shorter writes confirm that FFh comes back instead. A partial byte followed by a full byte, a clean rewrite after it, and an unknown command separate the flag's set, hold and clear paths from each other.

// File: rtl/sp_pkg.sv
// Shared definitions for the scratchpad engine: command codes, FSM states
// and the bit-serial CRC16 step (reflected polynomial, LSB first).
package sp_pkg;

    localparam logic [7:0]  CMD_WRITE = 8'h0F;
    localparam logic [7:0]  CMD_READ  = 8'hAA;
    localparam logic [15:0] CRC_POLY_R = 16'hA001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TA1,
        ST_TA2,
        ST_WDATA,
        ST_READ,
        ST_HOLD
    } sp_state_e;

    // One byte into the CRC, one bit at a time, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  din);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ din[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_R;
        end
        return c;
    endfunction

endpackage

// File: rtl/sp_crc16.sv
// Running CRC16 accumulator.
// Assumes: start and add are never high together; start seeds from zero.
module sp_crc16
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        add,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Clear-and-load on start, accumulate on add, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (start) begin
            crc <= crc16_step(16'h0000, din);
        end else if (add) begin
            crc <= crc16_step(crc, din);
        end
    end

endmodule

// File: rtl/sp_page_mem.sv
// Synchronous byte memory model: one load port, one read port with a
// one-cycle registered read. Contents are not reset.
module sp_page_mem #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [7:0] mem [DEPTH];

    // Load port write and registered read.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/sp_merge.sv
// Picks the byte that lands in the scratchpad for the addressed page:
// memory byte when locked, AND of both when AND-merge, else the sent byte.
// Assumes: the lock flag has priority over the AND-merge flag.
module sp_merge #(
    parameter int PAGES = 16,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic [PG_W-1:0]  page,
    input  logic [PAGES-1:0] page_wp,
    input  logic [PAGES-1:0] page_eprom,
    input  logic [7:0]       sent,
    input  logic [7:0]       old,
    output logic [7:0]       merged
);

    // Substitution by page mode.
    always_comb begin
        if (page_wp[page]) begin
            merged = old;
        end else if (page_eprom[page]) begin
            merged = sent & old;
        end else begin
            merged = sent;
        end
    end

endmodule

// File: rtl/sp_engine.sv
// Scratchpad write/readback command engine.
// Takes decoded bytes (with bit counts) from a bus front end, runs the
// write (0Fh) and read (AAh) commands, keeps the ending offset, the partial
// flag and a running CRC16, and returns outgoing bytes on request.
// Assumes: consecutive rx_valid pulses are at least two cycles apart, so
// the registered memory read for the current offset is ready in time.
module sp_engine
    import sp_pkg::*;
#(
    parameter int SP_BYTES = 32,
    parameter int PAGES    = 16,
    localparam int ADDR_W  = $clog2(SP_BYTES) + $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_end,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [3:0]        rx_bits,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic [PAGES-1:0]  page_wp,
    input  logic [PAGES-1:0]  page_eprom,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata
);

    localparam int OFF_W = $clog2(SP_BYTES);
    localparam int PG_W  = $clog2(PAGES);
    localparam int IDX_W = $clog2(SP_BYTES + 8);
    localparam int CNT_W = OFF_W + 1;
    localparam logic [OFF_W-1:0] OFF_TOP = OFF_W'(SP_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    sp_state_e                     state_q;
    logic [7:0]                    ta1_q;
    logic [7:0]                    ta2_q;
    logic [OFF_W-1:0]              off_q;
    logic [OFF_W-1:0]              e_q;
    logic                          pf_q;
    logic                          full_q;
    logic [SP_BYTES-1:0][7:0]      sp_q;
    logic [IDX_W-1:0]              rd_idx_q;
    logic [1:0]                    wcrc_idx_q;
    logic                          tx_valid_q;
    logic [7:0]                    tx_byte_q;

    logic                          full_byte;
    logic [15:0]                   ta_w;
    logic [OFF_W-1:0]              t_off;
    logic [PG_W-1:0]               page;
    logic [7:0]                    mem_rdata;
    logic [7:0]                    merged;
    logic [15:0]                   crc;
    logic [7:0]                    es_byte;
    logic [CNT_W-1:0]              data_cnt;
    logic [IDX_W-1:0]              body_end;
    logic                          rd_in_body;
    logic [OFF_W-1:0]              rd_off;
    logic [7:0]                    rd_byte;
    logic [7:0]                    wr_byte;
    logic [7:0]                    tx_next;
    logic                          crc_start;
    logic                          crc_add_rx;
    logic                          crc_add_tx;
    logic                          crc_add;
    logic [7:0]                    crc_din;

    assign full_byte = (rx_bits == 4'd8);
    assign ta_w      = {ta2_q, ta1_q};
    assign t_off     = ta1_q[OFF_W-1:0];
    assign page      = ta_w[ADDR_W-1:OFF_W];
    assign es_byte   = {{(7 - OFF_W){1'b0}}, pf_q, e_q};

    sp_page_mem #(
        .ADDR_W (ADDR_W)
    ) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr ({page, off_q}),
        .rdata (mem_rdata)
    );

    sp_merge #(
        .PAGES (PAGES)
    ) merge_i (
        .page       (page),
        .page_wp    (page_wp),
        .page_eprom (page_eprom),
        .sent       (rx_byte),
        .old        (mem_rdata),
        .merged     (merged)
    );

    sp_crc16 crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .add   (crc_add),
        .din   (crc_din),
        .crc   (crc)
    );

    // Read-back byte selection: header, buffer body, inverted CRC, then ones.
    always_comb begin
        data_cnt   = CNT_W'({1'b0, e_q}) - CNT_W'({1'b0, t_off}) + CNT_W'(1);
        body_end   = IDX_W'(3) + IDX_W'(data_cnt);
        rd_in_body = (rd_idx_q < body_end);
        rd_off     = t_off + OFF_W'(rd_idx_q - IDX_W'(3));
        if (rd_idx_q == IDX_W'(0)) begin
            rd_byte = ta1_q;
        end else if (rd_idx_q == IDX_W'(1)) begin
            rd_byte = ta2_q;
        end else if (rd_idx_q == IDX_W'(2)) begin
            rd_byte = es_byte;
        end else if (rd_in_body) begin
            rd_byte = sp_q[rd_off];
        end else if (rd_idx_q == body_end) begin
            rd_byte = ~crc[7:0];
        end else if (rd_idx_q == body_end + IDX_W'(1)) begin
            rd_byte = ~crc[15:8];
        end else begin
            rd_byte = 8'hFF;
        end
    end

    // Write-phase reply: inverted CRC once the top offset is written.
    always_comb begin
        wr_byte = 8'hFF;
        if (full_q) begin
            if (wcrc_idx_q == 2'd0) begin
                wr_byte = ~crc[7:0];
            end else if (wcrc_idx_q == 2'd1) begin
                wr_byte = ~crc[15:8];
            end
        end
    end

    // Outgoing byte by state.
    always_comb begin
        case (state_q)
            ST_READ:  tx_next = rd_byte;
            ST_WDATA: tx_next = wr_byte;
            default:  tx_next = 8'hFF;
        endcase
    end

    // CRC feed control: seed on a known command, add received or sent bytes.
    always_comb begin
        crc_start  = (state_q == ST_IDLE) && rx_valid && full_byte && !txn_end
                     && ((rx_byte == CMD_WRITE) || (rx_byte == CMD_READ));
        crc_add_rx = rx_valid && full_byte && !txn_end
                     && ((state_q == ST_TA1) || (state_q == ST_TA2)
                         || ((state_q == ST_WDATA) && !full_q));
        crc_add_tx = (state_q == ST_READ) && tx_req && rd_in_body && !txn_end;
        crc_add    = crc_add_rx || crc_add_tx;
        crc_din    = crc_add_tx ? rd_byte : rx_byte;
    end

    // Command sequencer, address/offset/flag registers and buffer writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ta1_q      <= '0;
            ta2_q      <= '0;
            off_q      <= '0;
            e_q        <= '0;
            pf_q       <= 1'b0;
            full_q     <= 1'b0;
            sp_q       <= '0;
            rd_idx_q   <= '0;
            wcrc_idx_q <= '0;
        end else if (txn_end) begin
            state_q    <= ST_IDLE;
            rd_idx_q   <= '0;
            wcrc_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rx_valid) begin
                        if (!full_byte) begin
                            state_q <= ST_HOLD;
                        end else if (rx_byte == CMD_WRITE) begin
                            state_q <= ST_TA1;
                            pf_q    <= 1'b0;
                            full_q  <= 1'b0;
                        end else if (rx_byte == CMD_READ) begin
                            state_q  <= ST_READ;
                            rd_idx_q <= '0;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_TA1: begin
                    if (rx_valid) begin
                        if (full_byte) begin
                            ta1_q   <= rx_byte;
                            off_q   <= rx_byte[OFF_W-1:0];
                            e_q     <= rx_byte[OFF_W-1:0];
                            state_q <= ST_TA2;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_TA2: begin
                    if (rx_valid) begin
                        if (full_byte) begin
                            ta2_q      <= rx_byte;
                            wcrc_idx_q <= '0;
                            state_q    <= ST_WDATA;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_WDATA: begin
                    if (rx_valid) begin
                        if (!full_byte) begin
                            pf_q    <= 1'b1;
                            state_q <= ST_HOLD;
                        end else if (!full_q) begin
                            sp_q[off_q] <= merged;
                            e_q         <= off_q;
                            if (off_q == OFF_TOP) begin
                                full_q <= 1'b1;
                            end else begin
                                off_q <= off_q + OFF_W'(1);
                            end
                        end
                    end
                    if (tx_req && full_q && (wcrc_idx_q != 2'd2)) begin
                        wcrc_idx_q <= wcrc_idx_q + 2'd1;
                    end
                end
                ST_READ: begin
                    if (tx_req && (rd_idx_q != IDX_MAX)) begin
                        rd_idx_q <= rd_idx_q + IDX_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Registered reply: valid one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= 1'b0;
            tx_byte_q  <= 8'hFF;
        end else begin
            tx_valid_q <= tx_req;
            if (tx_req) tx_byte_q <= tx_next;
        end
    end

    assign tx_valid = tx_valid_q;
    assign tx_byte  = tx_byte_q;

    AST_E_NOT_BELOW_T: assert property (@(posedge clk) disable iff (!rst_n)
        e_q >= t_off);  // R2

    AST_PF_RISES_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_q) |-> $past(state_q) == ST_WDATA);  // R3

    AST_FULL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> e_q == OFF_TOP);  // R6

    AST_BUF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_WDATA && rx_valid) |=> $stable(sp_q));  // R7

    AST_TX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);  // R10

    AST_NO_TX_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);  // R10

endmodule

// File: tb/sp_engine_tb_top.sv
// Self-checking bench: a table of write cases walked by one loop, each
// followed by a read-back, then directed reset and corner-case tests.
module sp_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAGES      = 16;
    localparam int ADDR_W     = 9;

    typedef struct packed {
        logic [7:0] ta1;
        logic [7:0] ta2;
        logic [5:0] n;
        logic [7:0] seed;
        logic [1:0] mode;   // bit0 locked, bit1 AND-merge
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h03, 8'h00, 6'd4,  8'h9C, 2'd0},
        '{8'h2A, 8'h00, 6'd3,  8'h17, 2'd1},
        '{8'h45, 8'h00, 6'd6,  8'hF0, 2'd2},
        '{8'h7C, 8'h00, 6'd6,  8'h66, 2'd0},
        '{8'h80, 8'h01, 6'd2,  8'h3B, 2'd3},
        '{8'hE0, 8'h00, 6'd32, 8'hA5, 2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              txn_end = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic [3:0]        rx_bits = 4'd8;
    logic              tx_req = 1'b0;
    logic              tx_valid;
    logic [7:0]        tx_byte;
    logic [PAGES-1:0]  page_wp = '0;
    logic [PAGES-1:0]  page_eprom = '0;
    logic              mem_we = 1'b0;
    logic [ADDR_W-1:0] mem_waddr = '0;
    logic [7:0]        mem_wdata = '0;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] bmem [512];
    logic [7:0] bsp  [32];
    logic [7:0] bta1 = '0;
    logic [7:0] bta2 = '0;
    logic [4:0] be   = '0;
    logic       bpf  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sp_engine #(.SP_BYTES(32), .PAGES(PAGES)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_end    (txn_end),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rx_bits    (rx_bits),
        .tx_req     (tx_req),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .page_wp    (page_wp),
        .page_eprom (page_eprom),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    // Byte-wise reflected CRC16 model (poly 0xA001, init supplied).
    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [3:0] bits);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_bits = bits;
        @(negedge clk);
        rx_valid = 1'b0; rx_bits = 4'd8;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        chk("R10 tx_valid after request", {15'd0, tx_valid}, 16'd1);
        b = tx_byte;
    endtask

    task automatic end_txn();
        @(negedge clk);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    task automatic preload(input logic [3:0] pg);
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            mem_we = 1'b1;
            mem_waddr = {pg, 5'(j)};
            mem_wdata = (8'(pg) * 8'd16 + 8'(j)) ^ 8'hC3;
            bmem[{pg, 5'(j)}] = mem_wdata;
        end
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    // Write command with model update; part_at < 0 means no partial byte.
    task automatic do_write(input logic [7:0] ta1, input logic [7:0] ta2,
                            input int n, input logic [7:0] seed,
                            input logic [1:0] mode, input int part_at);
        logic [3:0]  pg;
        logic [4:0]  off;
        logic [15:0] crc;
        logic [7:0]  d, got, m;
        logic        bfull, stopped;
        pg = {ta2[0], ta1[7:5]};
        page_wp    = mode[0] ? (PAGES'(1) << pg) : '0;
        page_eprom = mode[1] ? (PAGES'(1) << pg) : '0;
        crc = bcrc(16'h0000, 8'h0F);
        send(8'h0F, 4'd8);
        bpf = 1'b0; bfull = 1'b0; stopped = 1'b0;
        send(ta1, 4'd8); crc = bcrc(crc, ta1); bta1 = ta1;
        off = ta1[4:0]; be = off;
        send(ta2, 4'd8); crc = bcrc(crc, ta2); bta2 = ta2;
        for (int i = 0; i < n; i++) begin
            d = seed ^ 8'(i * 37);
            if (i == part_at) begin
                send(d, 4'd5);
                if (!stopped) bpf = 1'b1;
                stopped = 1'b1;
            end else begin
                send(d, 4'd8);
                if (!stopped && !bfull) begin
                    m = bmem[{pg, off}];
                    if (mode[0])      bsp[off] = m;
                    else if (mode[1]) bsp[off] = d & m;
                    else              bsp[off] = d;
                    be  = off;
                    crc = bcrc(crc, d);
                    if (off == 5'd31) bfull = 1'b1;
                    else off = off + 5'd1;
                end
            end
        end
        if (bfull && !stopped) begin
            get(got); chk("R6 write CRC low", {8'h00, got}, {8'h00, ~crc[7:0]});
            get(got); chk("R6 write CRC high", {8'h00, got}, {8'h00, ~crc[15:8]});
            get(got); chk("R6 ones after write CRC", {8'h00, got}, 16'h00FF);
        end else begin
            get(got); chk("R6 no CRC before top", {8'h00, got}, 16'h00FF);
        end
        end_txn();
    endtask

    // Read command checked against the model.
    task automatic do_read(input string hdr_tag, input string data_tag);
        logic [15:0] crc;
        logic [7:0]  got, es;
        logic [4:0]  t;
        send(8'hAA, 4'd8);
        crc = bcrc(16'h0000, 8'hAA);
        t  = bta1[4:0];
        es = {2'b00, bpf, be};
        get(got); chk({hdr_tag, " TA1"}, {8'h00, got}, {8'h00, bta1}); crc = bcrc(crc, bta1);
        get(got); chk({hdr_tag, " TA2"}, {8'h00, got}, {8'h00, bta2}); crc = bcrc(crc, bta2);
        get(got); chk({hdr_tag, " status"}, {8'h00, got}, {8'h00, es}); crc = bcrc(crc, es);
        for (int k = 0; k <= int'(be) - int'(t); k++) begin
            get(got);
            chk({data_tag, " data"}, {8'h00, got}, {8'h00, bsp[t + 5'(k)]});
            crc = bcrc(crc, bsp[t + 5'(k)]);
        end
        get(got); chk("R8 read CRC low", {8'h00, got}, {8'h00, ~crc[7:0]});
        get(got); chk("R8 read CRC high", {8'h00, got}, {8'h00, ~crc[15:8]});
        get(got); chk("R8 ones after CRC", {8'h00, got}, 16'h00FF);
        end_txn();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        string      tag;
        for (int j = 0; j < 32; j++) bsp[j] = 8'h00;
        repeat (4) @(negedge clk);
        chk("R1 tx_valid in reset", {15'd0, tx_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_valid after reset", {15'd0, tx_valid}, 16'd0);
        get(got); chk("R1 idle reply", {8'h00, got}, 16'h00FF);
        do_read("R1", "R1");

        // Table of write cases, each read back.
        for (int v = 0; v < NVEC; v++) begin
            preload({VECS[v].ta2[0], VECS[v].ta1[7:5]});
            do_write(VECS[v].ta1, VECS[v].ta2, int'(VECS[v].n), VECS[v].seed,
                     VECS[v].mode, -1);
            tag = (VECS[v].mode == 2'd1) ? "R4" : (VECS[v].mode != 2'd0) ? "R5" : "R2";
            do_read("R7", tag);
        end

        // Partial byte: dropped, flag set, later full byte ignored.
        do_write(8'h04, 8'h00, 4, 8'h11, 2'd0, 2);
        do_read("R3", "R3");

        // A fresh write clears the flag.
        do_write(8'h04, 8'h00, 1, 8'h22, 2'd0, -1);
        do_read("R9", "R9");

        // Unknown command: nothing changes, replies are ones.
        send(8'h33, 4'd8);
        get(got); chk("R9 unknown command reply", {8'h00, got}, 16'h00FF);
        send(8'h44, 4'd8);
        end_txn();
        do_read("R9", "R9");

        // Reply strobe lasts one cycle.
        get(got);
        @(negedge clk);
        chk("R10 tx_valid single cycle", {15'd0, tx_valid}, 16'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule